// File: doc/BRIEF.md
# Phase-Integrating FM Baseband Modulator

The block turns a stream of 16-bit signed frequency words into a complex baseband FM signal. Each word is the phase step to take in one sample. A code of 0x8000 is a step of -180 degrees, 0x0000 is no step, and 0x7FFF is a step just short of +180 degrees. On every cycle where the accumulate enable is high, the word is added into a phase register, and the sum wraps modulo 2^PHASE_W. A sine/cosine generator reads the whole phase register and produces an in-phase output (cosine) and a quadrature output (sine).

The frequency word comes from one of two sources. One is the raw in-phase sample stream. The other is the output of an upstream pulse-shaping filter, which is outside this block. A select input picks between them. When the enable is low, the phase holds and no new rotation occurs.

The generator keeps one quarter of a sine period in a table. The table is computed at elaboration with 2^QTR_BITS + 2 entries. The generator folds the phase into that quarter and interpolates linearly between neighbouring entries using the low phase bits. Both outputs are registered, so they follow the phase register with a latency of one cycle. Their amplitude peaks at AMP (default 32767).

Top module: `fm_nco_mod`

## Requirements
- R1: While reset is held low and on the first cycle after it, phase_o is 0, i_out is AMP (0x7FFF) and q_out is 0.
- R2: On a rising clock edge with acc_en high, phase_o becomes (phase_o + selected word) modulo 65536. The word is taken as an unsigned 16-bit pattern, so a sum crossing 0xFFFF wraps and never saturates.
- R3: On a rising clock edge with acc_en low, phase_o keeps its value whatever the frequency inputs carry. One cycle later the outputs stop changing as well.
- R4: src_shaped = 0 selects raw_freq and src_shaped = 1 selects shaped_freq. The input that is not selected has no effect on phase_o.
- R5: A word of 0x8000 advances the phase by exactly half a turn (0x8000). A word of 0x7FFF advances it by one code less than half a turn.
- R6: One cycle after phase_o holds P, i_out equals round(AMP*cos(2*pi*P/65536)) and q_out equals round(AMP*sin(2*pi*P/65536)), each within 3 LSB, as 16-bit two's complement values.
- R7: At the four cardinal phases the outputs are exact. P = 0x0000 gives (AMP, 0), 0x4000 gives (0, AMP), 0x8000 gives (-AMP, 0), and 0xC000 gives (0, -AMP).
- R8: The outputs never leave the range [-AMP, +AMP]. Their signs agree with the quadrant given by the top two phase bits: 00 gives sin >= 0 and cos >= 0; 01 gives sin >= 0 and cos <= 0; 10 gives sin <= 0 and cos <= 0; 11 gives sin <= 0 and cos >= 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en | input | 1 | Accumulate enable; phase holds when low |
| src_shaped | input | 1 | Source select: 0 raw word, 1 shaped word |
| raw_freq | input | 16 | Raw per-sample phase step, two's complement |
| shaped_freq | input | 16 | Pulse-shaped per-sample phase step, two's complement |
| phase_o | output | 16 | Current phase accumulator value |
| i_out | output | 16 | Cosine of the phase, two's complement, one cycle latency |
| q_out | output | 16 | Sine of the phase, two's complement, one cycle latency |

## Verification
The bench builds the block with its default parameters: a 16-bit phase, a 16-bit output, a quarter table with 8 address bits (so 6 interpolation bits), and AMP = 32767. With these values, a short run of directed steps reaches the wrap at 0xFFFF, the half-turn step codes, every quadrant boundary and the exact cardinal points. A long random stretch then sweeps all 64 interpolation fractions between table entries, compares each output sample against a floating-point cosine and sine, and toggles the enable and the source select freely.

// File: rtl/fm_nco_pkg.sv
package fm_nco_pkg;

  // One quarter-wave table entry: round(amp * sin(k * pi/2 / 2^qbits)), clamped past 90 deg
  function automatic int qsin_entry(input int k, input int qbits, input int amp);
    real ang;
    if (k >= (1 << qbits)) return amp;
    ang = 1.5707963267948966 * real'(k) / real'(1 << qbits);
    return $rtoi(real'(amp) * $sin(ang) + 0.5);
  endfunction

  // Linear interpolation between two neighbouring table entries
  function automatic int lerp(input int s0, input int s1, input int frac, input int fbits);
    return s0 + (((s1 - s0) * frac + (1 << (fbits - 1))) >>> fbits);
  endfunction

  // Phase advance, wrapping modulo 2^16 (the phase register truncates)
  function automatic logic [15:0] phase_step(input logic [15:0] p, input logic [15:0] f);
    return p + f;
  endfunction

endpackage

// File: rtl/fm_src_mux.sv
module fm_src_mux #(
  parameter int W = 16
) (
  input  logic         sel_shaped,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] shaped_i,
  output logic [W-1:0] freq_o
);
  always_comb freq_o = sel_shaped ? shaped_i : raw_i;
endmodule

// File: rtl/fm_phase_acc.sv
module fm_phase_acc #(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PHASE_W-1:0] freq_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_nxt;

  always_comb phase_nxt = PHASE_W'(fm_nco_pkg::phase_step(16'(phase_q), 16'(freq_i)));

  always_ff @(posedge clk) begin
    if (!rst_n)  phase_q <= '0;
    else if (en) phase_q <= phase_nxt;
  end

  assign phase_o = phase_q;

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(phase_q));
endmodule

// File: rtl/fm_sincos_gen.sv
module fm_sincos_gen #(
  parameter int PHASE_W  = 16,
  parameter int OUT_W    = 16,
  parameter int QTR_BITS = 8,
  parameter int AMP      = 32767
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PHASE_W-1:0]      phase_i,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);
  localparam int QW      = PHASE_W - 2;          // bits inside one quadrant
  localparam int FB      = QW - QTR_BITS;        // interpolation fraction bits
  localparam int TAB_N   = (1 << QTR_BITS) + 2;  // quarter plus guard entries
  localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << QW;

  logic signed [OUT_W-1:0] tab [TAB_N];

  for (genvar k = 0; k < TAB_N; k++) begin : g_tab
    assign tab[k] = OUT_W'(fm_nco_pkg::qsin_entry(k, QTR_BITS, AMP));
  end

  // channel 0 = sine of phase, channel 1 = sine of phase + quarter turn (cosine)
  logic signed [OUT_W-1:0] ch_val [2];

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [PHASE_W-1:0] p;
    logic [1:0]         quad;
    logic [QW:0]        x;
    logic [QTR_BITS:0]  idx;
    logic [FB-1:0]      frac;
    int                 mag;

    always_comb begin
      p    = phase_i + ((ch == 1) ? QUARTER : '0);
      quad = p[PHASE_W-1 -: 2];
      x    = quad[0] ? ((QW+1)'(1) << QW) - {1'b0, p[QW-1:0]} : {1'b0, p[QW-1:0]};
      idx  = x[QW:FB];
      frac = x[FB-1:0];
      mag  = fm_nco_pkg::lerp(int'(tab[int'(idx)]), int'(tab[int'(idx) + 1]),
                              int'(frac), FB);
      ch_val[ch] = OUT_W'(quad[1] ? -mag : mag);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cos_o <= OUT_W'(AMP);
      sin_o <= '0;
    end else begin
      cos_o <= ch_val[1];
      sin_o <= ch_val[0];
    end
  end

  // R7
  zero_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_i) == '0) |-> (cos_o == OUT_W'(AMP) && sin_o == '0));
  // R7
  half_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_i) == (QUARTER << 1)) |-> (cos_o == -OUT_W'(AMP) && sin_o == '0));
  // R8
  amp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cos_o) <= AMP && int'(cos_o) >= -AMP && int'(sin_o) <= AMP && int'(sin_o) >= -AMP));
  // R8
  sin_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phase_i[PHASE_W-1]) ? (sin_o <= 0) : (sin_o >= 0));
  // R8
  cos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_i[PHASE_W-1]) ^ $past(phase_i[PHASE_W-2])) ? (cos_o <= 0) : (cos_o >= 0));
endmodule

// File: rtl/fm_nco_mod.sv
module fm_nco_mod #(
  parameter int PHASE_W  = 16,
  parameter int OUT_W    = 16,
  parameter int QTR_BITS = 8,
  parameter int AMP      = 32767
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_en,
  input  logic                    src_shaped,
  input  logic [PHASE_W-1:0]      raw_freq,
  input  logic [PHASE_W-1:0]      shaped_freq,
  output logic [PHASE_W-1:0]      phase_o,
  output logic signed [OUT_W-1:0] i_out,
  output logic signed [OUT_W-1:0] q_out
);
  logic [PHASE_W-1:0] freq_sel;
  wire                step_raw    = acc_en && !src_shaped;
  wire                step_shaped = acc_en && src_shaped;

  fm_src_mux #(.W(PHASE_W)) i_mux (
    .sel_shaped (src_shaped),
    .raw_i      (raw_freq),
    .shaped_i   (shaped_freq),
    .freq_o     (freq_sel)
  );

  fm_phase_acc #(.PHASE_W(PHASE_W)) i_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (acc_en),
    .freq_i  (freq_sel),
    .phase_o (phase_o)
  );

  fm_sincos_gen #(.PHASE_W(PHASE_W), .OUT_W(OUT_W), .QTR_BITS(QTR_BITS), .AMP(AMP)) i_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase_o),
    .cos_o   (i_out),
    .sin_o   (q_out)
  );

  // R2 R4
  raw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_raw |=> phase_o == PHASE_W'($past(phase_o) + $past(raw_freq)));
  // R2 R4
  shaped_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_shaped |=> phase_o == PHASE_W'($past(phase_o) + $past(shaped_freq)));
endmodule

// File: tb/test_fm_nco_mod.sv
module test_fm_nco_mod;
  localparam int AMP = 32767;
  localparam int TOL = 3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_en = 0;
  logic        src_shaped = 0;
  logic [15:0] raw_freq = 0;
  logic [15:0] shaped_freq = 0;
  logic [15:0] phase_o;
  logic signed [15:0] i_out, q_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int exp_phase = 0;   // model accumulator
  int out_phase = 0;   // phase the outputs should reflect

  always #10 clk = ~clk;  // 50 MHz

  fm_nco_mod i_fm_nco_mod (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .src_shaped(src_shaped),
    .raw_freq(raw_freq), .shaped_freq(shaped_freq),
    .phase_o(phase_o), .i_out(i_out), .q_out(q_out)
  );

  task automatic check_int(input string tag, input string what, input int act, input int exp, input int tol);
    checks++;
    if (act > exp + tol || act < exp - tol) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    real ang;
    int ec, es, t;
    bit cardinal;
    check_int(tag, "phase", int'(phase_o), exp_phase, 0);
    ang = 6.283185307179586 * real'(out_phase) / 65536.0;
    ec = int'(real'(AMP) * $cos(ang));
    es = int'(real'(AMP) * $sin(ang));
    cardinal = (out_phase % 16384) == 0;
    t = cardinal ? 0 : TOL;
    check_int(cardinal ? "R7" : "R6", "i_out", int'(i_out), ec, t);
    check_int(cardinal ? "R7" : "R6", "q_out", int'(q_out), es, t);
  endtask

  task automatic step(input bit en, input bit shp, input logic [15:0] rf, input logic [15:0] sf, input string tag);
    acc_en = en; src_shaped = shp; raw_freq = rf; shaped_freq = sf;
    @(posedge clk);
    out_phase = exp_phase;
    if (en) exp_phase = (exp_phase + int'(shp ? sf : rf)) % 65536;
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    check_int("R1", "phase in reset", int'(phase_o), 0, 0);
    check_int("R1", "i_out in reset", int'(i_out), AMP, 0);
    check_int("R1", "q_out in reset", int'(q_out), 0, 0);
    rst_n = 1;
    step(0, 0, 16'h1234, 16'h4321, "R1");
    // R2/R7: quarter turns through all cardinal points; unselected input is noise
    for (int k = 0; k < 5; k++) step(1, 0, 16'h4000, 16'h1357, "R4");
    // R3: hold while idle with changing inputs
    for (int k = 0; k < 4; k++) step(0, k[0], 16'(k * 977 + 5), 16'(k * 311 + 9), "R3");
    // R5: half-turn steps
    step(1, 0, 16'h8000, 16'h0001, "R5");
    step(1, 1, 16'h0002, 16'h8000, "R5");
    step(1, 0, 16'h7FFF, 16'h0000, "R5");
    step(1, 0, 16'h7FFF, 16'h0000, "R5");
    // R2: wrap past 0xFFFF
    step(1, 0, 16'((32'hFFF0 - exp_phase) & 32'hFFFF), 16'h5555, "R2");
    step(1, 0, 16'h0020, 16'h5555, "R2");
    // R4: shaped source with raw noise
    for (int k = 0; k < 6; k++) step(1, 1, 16'hA5A5, 16'(16'h0733 * (k + 1)), "R4");
    // R8 / R6: random sweep
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom;
      step(r[0] | r[1], r[2], 16'($urandom), 16'($urandom), "R8");
    end
    step(0, 0, 16'h0000, 16'h0000, "R3");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule